// File: doc/BRIEF.md
# Four-Lane 7:1 Display Serializer

This block turns one 28-bit parallel word per pixel clock into four serial data lanes and a forwarded clock lane. The parallel word is captured on the falling edge of the pixel clock. A bit clock running at exactly seven times the pixel rate is supplied from outside, phase-locked to the pixel clock. Each lane carries a 7-bit slice of the word per pixel period.

The forwarded clock lane repeats a fixed 7-bit pattern once per slice, so its frequency equals the pixel clock's. A receiver uses this pattern to find slice boundaries. A static narrow input selects a 21-bit setup in which only three lanes carry data. The active-low shutdown input clears every register in both clock domains and holds all outputs low. After shutdown is released, the outputs stay low until the first complete captured word has been handed to the shifters.

Top module: `pix_lane_serializer`

## Requirements
- R1: The 28-bit word on `din` is captured on the falling edge of `pix_clk`. Every captured word is transmitted once, in capture order. This starts with the first capture after shutdown is released.
- R2: Lane k carries word bits 7k to 7k+6: lane 0 has bits 0-6 and lane 3 has bits 21-27. The lowest-numbered bit of each slice goes out first, one bit per `bit_clk` cycle.
- R3: A new slice starts every seven `bit_clk` cycles, with no idle cycle between slices.
- R4: `clk_lane_o` repeats the sequence 1,1,0,0,0,1,1 in transmit order. Its first 1 falls in the same bit period as bit 0 of every data slice.
- R5: While `shdn_n` is low, `lane_o` and `clk_lane_o` are all 0.
- R6: Shutdown clears all stored data. A word captured before shutdown never appears after release.
- R7: After `shdn_n` rises, all outputs stay 0 until the first complete word starts. The first nonzero output bit is bit 0 of a slice.
- R8: When `narrow` is 1 at a capture edge, that word's lane 3 slice is all 0. Lanes 0-2 still carry bits 0-20.
- R9: The slot index in the bit-clock domain stays within 0..6 and wraps from 6 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk | input | 1 | Pixel-rate clock; data captured on its falling edge |
| bit_clk | input | 1 | Bit clock at 7x the pixel rate, phase-locked to `pix_clk` |
| shdn_n | input | 1 | Active-low shutdown and asynchronous clear |
| narrow | input | 1 | 1 selects the 21-bit setup (lane 3 held low) |
| din | input | 28 | Parallel input word |
| lane_o | output | 4 | Serial data lanes, bit k is lane k |
| clk_lane_o | output | 1 | Forwarded clock lane bit stream |

## Verification
The bench frames the output with the clock-lane pattern. It then rebuilds each 28-bit word and compares it against the words applied at falling pixel edges. A design that captured on the wrong edge would deliver the sequence shifted by one word. Wrong lane mapping or bit order would scramble walking-one words. A gap between slices would break the clock-lane pattern check made on every bit.

Shutdown is asserted in the middle of a stream while the input holds a distinctive word. A design that kept stale holding data, or emitted a partial slice after release, would show a word that was never applied, or a clock-lane 1 out of phase. Narrow-mode words carry ones in bits 21-27 at the input. A lane 3 that is not held low shows up as a miscompare.

// File: rtl/pix_lane_serializer.sv
module pix_lane_serializer #(
  parameter int LANES = 4,
  parameter int SLICE = 7,
  parameter logic [SLICE-1:0] CLK_PAT = 7'b1100011
) (
  input  logic                   pix_clk,
  input  logic                   bit_clk,
  input  logic                   shdn_n,
  input  logic                   narrow,
  input  logic [LANES*SLICE-1:0] din,
  output logic [LANES-1:0]       lane_o,
  output logic                   clk_lane_o
);
  localparam int W  = LANES * SLICE;
  localparam int CW = $clog2(SLICE);
  localparam logic [CW-1:0] LAST = CW'(SLICE - 1);

  logic [W-1:0] hold_q;
  logic         hold_tgl;

  always_ff @(negedge pix_clk or negedge shdn_n)
    if (!shdn_n) begin
      hold_q   <= '0;
      hold_tgl <= 1'b0;
    end else begin
      hold_q   <= narrow ? {{SLICE{1'b0}}, din[W-SLICE-1:0]} : din;
      hold_tgl <= ~hold_tgl;
    end

  logic [2:0]       sync;
  logic             running;
  logic [CW-1:0]    slot;
  logic [SLICE-1:0] ck_sr;
  logic [SLICE-1:0] sr [LANES];

  wire new_word = sync[2] ^ sync[1];
  wire load     = running ? (slot == LAST) : new_word;

  always_ff @(posedge bit_clk or negedge shdn_n)
    if (!shdn_n) begin
      sync    <= '0;
      running <= 1'b0;
      slot    <= '0;
      ck_sr   <= '0;
    end else begin
      sync <= {sync[1:0], hold_tgl};
      if (load) begin
        running <= 1'b1;
        slot    <= '0;
        ck_sr   <= CLK_PAT;
      end else begin
        slot  <= running ? slot + 1'b1 : slot;
        ck_sr <= {1'b0, ck_sr[SLICE-1:1]};
      end
    end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge bit_clk or negedge shdn_n)
      if (!shdn_n)   sr[l] <= '0;
      else if (load) sr[l] <= hold_q[l*SLICE +: SLICE];
      else           sr[l] <= {1'b0, sr[l][SLICE-1:1]};
    assign lane_o[l] = running & sr[l][0];
  end

  assign clk_lane_o = running & ck_sr[0];
endmodule

module pix_lane_serializer_chk #(
  parameter int LANES = 4,
  parameter int SLICE = 7
) (
  input logic                     bit_clk,
  input logic                     shdn_n,
  input logic                     running,
  input logic [$clog2(SLICE)-1:0] slot,
  input logic [LANES-1:0]         lane_o,
  input logic                     clk_lane_o
);
  always @(negedge bit_clk)
    if (!shdn_n)
      assert_quiet_in_shutdown_R5: assert (lane_o == '0 && !clk_lane_o)
        else $error("outputs active during shutdown");

  assert_slot_range_R9: assert property (@(posedge bit_clk) disable iff (!shdn_n)
    slot <= ($clog2(SLICE))'(SLICE - 1));

  assert_slot_wrap_R3: assert property (@(posedge bit_clk) disable iff (!shdn_n)
    (running && slot == ($clog2(SLICE))'(SLICE - 1)) |=> (running && slot == '0));

  assert_gated_until_load_R7: assert property (@(posedge bit_clk) disable iff (!shdn_n)
    !running |-> (lane_o == '0 && !clk_lane_o));

  assert_clk_start_aligned_R4: assert property (@(posedge bit_clk) disable iff (!shdn_n)
    (running && slot == '0) |-> clk_lane_o);

  assert_clk_pair_R4: assert property (@(posedge bit_clk) disable iff (!shdn_n)
    $rose(clk_lane_o) |=> clk_lane_o);
endmodule

bind pix_lane_serializer pix_lane_serializer_chk #(.LANES(LANES), .SLICE(SLICE)) u_chk (
  .bit_clk(bit_clk), .shdn_n(shdn_n), .running(running), .slot(slot),
  .lane_o(lane_o), .clk_lane_o(clk_lane_o)
);

// File: tb/test_pix_lane_serializer.sv
module test_pix_lane_serializer;
  localparam logic [6:0] PAT = 7'b1100011;

  logic        pix_clk = 1'b1;
  logic        bit_clk = 1'b0;
  logic        shdn_n  = 1'b0;
  logic        narrow  = 1'b0;
  logic [27:0] din     = '0;
  logic [3:0]  lane_o;
  logic        clk_lane_o;

  int n_chk = 0, n_bad = 0;
  logic [27:0] expq[$];
  logic [27:0] acc;
  bit locked = 0;
  int idx = 0;
  logic [31:0] lfsr = 32'hACE1_1234;

  pix_lane_serializer i_pix_lane_serializer (
    .pix_clk(pix_clk), .bit_clk(bit_clk), .shdn_n(shdn_n), .narrow(narrow),
    .din(din), .lane_o(lane_o), .clk_lane_o(clk_lane_o)
  );

  always #4 bit_clk = ~bit_clk;
  initial begin #2; forever #28 pix_clk = ~pix_clk; end

  always @(negedge pix_clk)
    if (shdn_n) expq.push_back(narrow ? {7'b0, din[20:0]} : din);

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge bit_clk) begin
    if (!shdn_n) begin
      check(lane_o == 0 && !clk_lane_o, "R5", {27'b0, clk_lane_o, lane_o}, 0);
      locked = 0;
    end else begin
      if (!locked) begin
        if (clk_lane_o) begin locked = 1; idx = 0; acc = '0; end
        else check(lane_o == 0, "R7", {28'b0, lane_o}, 0);
      end
      if (locked) begin
        check(clk_lane_o == PAT[idx], "R4", {31'b0, clk_lane_o}, {31'b0, PAT[idx]});
        for (int l = 0; l < 4; l++) acc[l*7 + idx] = lane_o[l];
        if (idx == 6) begin
          if (expq.size() == 0) check(0, "R1", {4'b0, acc}, 0);
          else begin
            logic [27:0] e;
            e = expq.pop_front();
            check(acc == e, "R1 R2 R3 R6 R8", {4'b0, acc}, {4'b0, e});
          end
          idx = 0;
        end else idx++;
      end
    end
  end

  task automatic send(logic [27:0] w, bit nar);
    @(posedge pix_clk); #1;
    din = w; narrow = nar;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    din = 28'h5A5A5A5;
    repeat (3) @(posedge pix_clk);
    #1 shdn_n = 1'b1; din = 28'h0000001;
    // R2: walking one over every bit position
    for (int b = 1; b < 28; b++) send(28'h1 << b, 0);
    send(28'hFFFFFFF, 0);
    send(28'h0000000, 0);
    send(28'hAAAAAAA, 0);
    send(28'h5555555, 0);
    for (int k = 0; k < 40; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      send(lfsr[27:0], 0);
    end
    // R8: narrow words with ones above bit 20
    for (int k = 0; k < 16; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      send(lfsr[27:0] | 28'hFE00000, 1);
    end
    send(28'h1234567, 0);
    // R5 R6: shutdown mid-stream with a distinctive word waiting
    send(28'hBADCAFE, 0);
    @(posedge pix_clk); #1;
    shdn_n = 1'b0; expq.delete();
    din = 28'hFFFFFFF;
    repeat (4) @(posedge pix_clk);
    #1 shdn_n = 1'b1; din = 28'h0F0F0F0;
    for (int k = 0; k < 30; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      send(lfsr[27:0], k[0]);
    end
    repeat (4) @(posedge pix_clk);
    finish_run();
  end
endmodule